// File: doc/BRIEF.md
# Multiplexed External Memory Port

This block connects an internal client to an external memory of 2^14 bytes over a narrow pin budget. The low eight address bits and the data byte share one 8-bit bus. Six more outputs carry the upper address bits. Timing is set by an address strobe that runs without pause. Each strobe period is one access slot of four internal clocks: two with the strobe high and two with it low. Outside logic may latch the low address byte on the falling edge of the strobe.

The client raises a request with a direction, an address and, for a write, a data byte. It holds the request until it sees a one-clock acknowledge. A request that is present on the last clock of an idle slot runs in the next slot. While the strobe is high, the port drives the low address byte onto the shared bus. While the strobe is low, the bus carries the write data, or the bus is released so that the memory can drive read data. The active-low output enable and write enable are only asserted in the strobe-low half, and never together. The port samples read data on the last clock of the slot. It returns that data with the acknowledge on the first clock of the following slot, which is always idle.

The shared bus is modelled as three plain ports: a value to drive, a drive enable, and the value seen on the pins.

Top module: `mux_mem_port`

## Requirements
- R1: While reset is held, and on the first clock after it, the strobe is high, both enables are high (inactive), the bus drive enable is 0 and the acknowledge is 0.
- R2: The strobe is high for exactly two clocks and then low for exactly two clocks. This repeats with or without requests, with slot clock 0 being the first clock after reset.
- R3: During an active slot, the high address outputs equal address bits 13..8 of the request being served.
- R4: During the strobe-high half of an active slot, the bus drive enable is 1 and the bus output equals address bits 7..0.
- R5: During the strobe-low half of a write slot, the bus drive enable is 1, the bus output equals the write data, the write enable is 0 and the output enable is 1.
- R6: During the strobe-low half of a read slot, the bus drive enable is 0, the output enable is 0 and the write enable is 1.
- R7: The output enable and the write enable are never low at the same time, and both are high whenever the strobe is high.
- R8: In an idle slot, the bus drive enable is 0 and both enables stay high.
- R9: The read data output takes the value on the bus input during the last clock of the read slot. The value on the earlier strobe-low clock does not affect it.
- R10: The acknowledge is 1 for exactly one clock: the first clock of the slot after the access, for reads and for writes alike.
- R11: A request is taken only on the last clock of an idle slot. The slot after an access is always idle, so a request still held on the acknowledge clock is not repeated in that slot. It runs again only in the slot after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Access address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with acknowledge |
| mem_strobe | output | 1 | Continuously cycling address strobe |
| mem_addr_hi | output | 6 | Address bits 13..8 |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_drive | output | 1 | Shared bus drive enable |
| bus_in | input | 8 | Value present on the shared bus |

## Verification
The slot counter is the one piece of state that everything else hangs on. If it slips, the strobe waveform breaks its two-high, two-low pattern within a single slot, and the enables and the bus drive move to the wrong half. A lost or stuck active flag shows up within one slot, either as a driven bus with enables in an idle slot or as a missing or repeated acknowledge. Read data captured on the wrong clock can only be seen if the bus input changes between the two strobe-low clocks, so the stimulus changes it there.

// File: rtl/mux_mem_port.sv
module mux_mem_port #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int HALF_CLKS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ack,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     mem_strobe,
  output logic [ADDR_W-DATA_W-1:0] mem_addr_hi,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_drive,
  input  logic [DATA_W-1:0]        bus_in
);
  localparam int SLOT = 2 * HALF_CLKS;
  localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam int HI_W = ADDR_W - DATA_W;

  logic [CW-1:0]     cnt;
  logic              act, wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ack_q;

  wire last   = (cnt == CW'(SLOT - 1));
  wire hi_phs = (cnt < CW'(HALF_CLKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act     <= 1'b0;
      wr      <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      cnt   <= last ? '0 : cnt + 1'b1;
      ack_q <= act && last;
      if (act && !wr && last)
        rdata_q <= bus_in;
      if (last) begin
        act <= req_valid && !act;
        if (req_valid && !act) begin
          wr      <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
      end
    end
  end

  assign mem_strobe  = hi_phs;
  assign mem_addr_hi = addr_q[ADDR_W-1 -: HI_W];
  assign bus_out     = hi_phs ? addr_q[DATA_W-1:0] : wdata_q;
  assign bus_drive   = act && (hi_phs || wr);
  assign mem_oe_n    = !(act && !wr && !hi_phs);
  assign mem_we_n    = !(act && wr && !hi_phs);
  assign req_ack     = ack_q;
  assign rsp_rdata   = rdata_q;

  assert_enables_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_enables_off_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> (mem_oe_n && mem_we_n));
  assert_strobe_low_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_strobe) |=> !mem_strobe);
  assert_strobe_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_strobe) |=> mem_strobe);
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  assert_idle_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (!bus_drive && mem_oe_n && mem_we_n));
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !bus_drive);
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> bus_drive);
  assert_hi_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> $stable(mem_addr_hi));
endmodule

// File: tb/tb_mux_mem_port.sv
module tb_mux_mem_port;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_in = '0;
  logic        req_ack, mem_strobe, mem_oe_n, mem_we_n, bus_drive;
  logic [7:0]  rsp_rdata, bus_out;
  logic [5:0]  mem_addr_hi;
  logic [1:0]  bp;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) bp <= rst_n ? bp + 2'd1 : 2'd0;

  mux_mem_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_strobe(mem_strobe), .mem_addr_hi(mem_addr_hi),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .bus_out(bus_out),
    .bus_drive(bus_drive), .bus_in(bus_in)
  );

  // {write, addr[13:0], wdata[7:0], read bus value[7:0]}
  localparam logic [30:0] VEC [6] = '{
    {1'b1, 14'h3FFF, 8'hA5, 8'h00},
    {1'b0, 14'h0000, 8'h00, 8'h3C},
    {1'b1, 14'h2A55, 8'h00, 8'h00},
    {1'b0, 14'h15AA, 8'h00, 8'hFF},
    {1'b1, 14'h0100, 8'hFF, 8'h00},
    {1'b0, 14'h3E01, 8'h00, 8'h81}
  };

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", r, a, e, $time);
    end
  endtask

  task automatic to_bp(input logic [1:0] p);
    do @(negedge clk); while (bp != p);
  endtask

  task automatic idle_half_checks(input string tag);
    chk({tag, " R8 drive"}, bus_drive, 0);
    chk({tag, " R8 oe_n"}, mem_oe_n, 1);
    chk({tag, " R8 we_n"}, mem_we_n, 1);
  endtask

  task automatic access(input logic w, input logic [13:0] a, input logic [7:0] d,
                        input logic [7:0] bin, input bit hold);
    to_bp(2);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    to_bp(3);
    idle_half_checks("pre");
    for (int k = 0; k < 2; k++) begin
      to_bp(2'(k));
      chk("R2 strobe high", mem_strobe, 1);
      chk("R4 drive", bus_drive, 1);
      chk("R4 low addr", bus_out, a[7:0]);
      chk("R3 high addr", mem_addr_hi, a[13:8]);
      chk("R7 enables off", {mem_oe_n, mem_we_n}, 2'b11);
      chk("R10 no ack", req_ack, 0);
    end
    to_bp(2);
    bus_in = ~bin;
    for (int k = 2; k < 4; k++) begin
      if (k == 3) begin to_bp(3); bus_in = bin; end
      chk("R2 strobe low", mem_strobe, 0);
      chk("R3 high addr", mem_addr_hi, a[13:8]);
      if (w) begin
        chk("R5 drive", bus_drive, 1);
        chk("R5 data", bus_out, d);
        chk("R5 we_n/oe_n", {mem_we_n, mem_oe_n}, 2'b01);
      end else begin
        chk("R6 release", bus_drive, 0);
        chk("R6 oe_n/we_n", {mem_oe_n, mem_we_n}, 2'b01);
      end
    end
    to_bp(0);
    chk("R10 ack", req_ack, 1);
    if (!w) chk("R9 rdata", rsp_rdata, bin);
    chk("R11 idle after access", bus_drive, 0);
    bus_in = 8'h00;
    if (!hold) req_valid = 1'b0;
    to_bp(1);
    chk("R10 ack one clock", req_ack, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", mem_strobe, 1);
    chk("R1 enables in reset", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R1 drive in reset", bus_drive, 0);
    chk("R1 ack in reset", req_ack, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 strobe after reset", mem_strobe, 1);
    chk("R1 idle after reset", {bus_drive, mem_oe_n, mem_we_n, req_ack}, 4'b0110);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2 free-running strobe", mem_strobe, (bp < 2) ? 1 : 0);
      idle_half_checks("R2 idle");
    end

    for (int i = 0; i < 6; i++)
      access(VEC[i][30], VEC[i][29:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R11: request raised after the slot's last clock waits for the next slot
    to_bp(0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h0042; req_wdata = 8'h99;
    to_bp(1);
    chk("R11 late request waits", bus_drive, 0);
    to_bp(2);
    idle_half_checks("R11 late");
    to_bp(0);
    chk("R11 late request runs", {bus_drive, bus_out}, {1'b1, 8'h42});
    to_bp(0);
    chk("R10 late ack", req_ack, 1);
    req_valid = 1'b0;

    // R11: request held through acknowledge is not repeated in the next slot
    access(1'b0, 14'h2222, 8'h00, 8'h5A, 1'b1);
    to_bp(2);
    idle_half_checks("R11 held");
    to_bp(3);
    idle_half_checks("R11 held");
    to_bp(0);
    chk("R11 held request reissued", {bus_drive, mem_addr_hi}, {1'b1, 6'h22});
    req_valid = 1'b0;
    to_bp(0);
    chk("R10 reissue ack", req_ack, 1);
    chk("R9 reissue data", rsp_rdata, 8'h00);
    to_bp(2);
    idle_half_checks("R8 after");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule